// File: doc/BRIEF.md
# Register Poison Bit Tracker

This block keeps a one-bit "poison" mark for every architectural register so that a terminating exception raised by an instruction the compiler hoisted above a branch can be held back. Such an instruction does not fault. It marks its destination register instead. The mark follows the value through any further speculative instructions that consume it. Only when a non-speculative instruction reads a marked register does the block raise a fault, and it names the register that caused it.

Each cycle the issue stage presents at most one instruction to the tracker. The instruction carries:
- a speculative flag;
- two optional source indices;
- an optional destination write;
- a terminating-exception flag and a resumable-exception flag;
- a store flag.

A context-switch path reads the whole poison vector, which is always visible on an output, and writes it back in a single cycle. Register values and the functional units are outside this block.

Top module: `poison_tracker`

## Requirements
- R1: While reset is held low at a clock edge, every poison bit is cleared and `fault`, `fault_reg`, `illegal_store` and `resum_pass` are zero on the following cycle.
- R2: A speculative non-store instruction with `term_exc` high and a write to a nonzero destination sets that destination's poison bit, seen on `poison_vec` one cycle later, and raises no fault.
- R3: A speculative non-store instruction that writes a nonzero destination leaves that bit set if any enabled source is poisoned or `term_exc` is high, and clear otherwise. A source whose enable is low is never considered.
- R4: A non-speculative instruction, store or not, with at least one enabled poisoned source raises `fault` on the next cycle. In that cycle `fault_reg` holds a poisoned source index. `fault_reg` is zero whenever `fault` is low.
- R5: When a fault is raised, the instruction's destination write is discarded. If both sources are poisoned, `fault_reg` reports the lower index.
- R6: A non-speculative non-store instruction with no poisoned enabled source clears its nonzero destination's poison bit, whatever its exception flags.
- R7: Register 0 is never poisoned. A write to index 0 changes no bit, and reading source 0 never counts as poisoned.
- R8: A store with the speculative flag set raises `illegal_store` on the next cycle, raises no fault and leaves the poison vector unchanged. A store never writes its destination.
- R9: `resum_exc` on an accepted operation (not an illegal store) raises `resum_pass` one cycle later and has no effect on any poison bit.
- R10: With `restore_we` high, `poison_vec` on the next cycle equals `restore_data` with bit 0 forced to zero. Any instruction presented in the same cycle is ignored and raises no output flag. `poison_vec` always shows the current state, which serves as the save path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | An instruction is presented this cycle |
| op_spec | input | 1 | The instruction is speculative |
| src0_en | input | 1 | First source is read |
| src0_idx | input | 5 | First source register index |
| src1_en | input | 1 | Second source is read |
| src1_idx | input | 5 | Second source register index |
| dst_we | input | 1 | The instruction writes a destination |
| dst_idx | input | 5 | Destination register index |
| term_exc | input | 1 | The instruction hit a terminating exception |
| resum_exc | input | 1 | The instruction hit a resumable exception |
| is_store | input | 1 | The instruction is a store |
| restore_we | input | 1 | Load the whole poison vector from `restore_data` |
| restore_data | input | 32 | Poison vector to restore |
| fault | output | 1 | Deferred fault from a non-speculative poisoned read |
| fault_reg | output | 5 | Register that caused the fault |
| illegal_store | output | 1 | A store arrived marked speculative |
| resum_pass | output | 1 | Resumable exception handed on for normal handling |
| poison_vec | output | 32 | Current poison bits, one per register |

## Verification
The assertions assume that every input is settled and known at each rising edge. They also assume that the instruction fields are meaningful only while `op_valid` is high. That is why each property qualifies its trigger with `op_valid` and with `restore_we` low. The bench changes inputs only on falling edges. It draws source and destination indices mostly from the low registers, so that poisoned reads, doubly poisoned sources and writes to register 0 all occur often. Restores are rare, so that poison can build up between them.

// File: rtl/poison_pkg.sv
// Package: shared sizing defaults and the write decision type for the
// poison tracker. Assumes one instruction per cycle with two sources.
package poison_pkg;

    localparam int DEF_NREG = 32;
    localparam int DEF_NSRC = 2;

    // What the tracker does to the destination poison bit this cycle
    typedef enum logic [1:0] {
        WR_NONE  = 2'd0,
        WR_CLEAR = 2'd1,
        WR_SET   = 2'd2
    } wr_act_e;

endpackage

// File: rtl/poison_src_check.sv
// Module: looks up the poison bit of each enabled source and picks the
// lowest-numbered poisoned source as the fault cause.
// Assumes: register 0 is kept clean by the storage, so no special case here.
module poison_src_check #(
    parameter int NREG  = poison_pkg::DEF_NREG,
    parameter int NSRC  = poison_pkg::DEF_NSRC,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic [NREG-1:0]            poison_vec,
    input  logic [NSRC-1:0]            src_en,
    input  logic [NSRC-1:0][IDX_W-1:0] src_idx,
    output logic                       any_hit,
    output logic [IDX_W-1:0]           cause_idx
);

    logic [NSRC-1:0] hit;

    // Per-source poison lookup, one copy per source port
    for (genvar s = 0; s < NSRC; s++) begin : g_src
        assign hit[s] = src_en[s] & poison_vec[src_idx[s]];
    end

    assign any_hit = |hit;

    // Lowest poisoned source index across all ports
    always_comb begin
        logic found;
        found     = 1'b0;
        cause_idx = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (hit[s] && (!found || src_idx[s] < cause_idx)) begin
                cause_idx = src_idx[s];
                found     = 1'b1;
            end
        end
    end

endmodule

// File: rtl/poison_decide.sv
// Module: combinational decision for one instruction: illegal store,
// deferred fault, resumable pass-through and the destination action.
// Assumes: restore_we takes priority and cancels the instruction.
module poison_decide #(
    parameter int NREG  = poison_pkg::DEF_NREG,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic                     op_valid,
    input  logic                     op_spec,
    input  logic                     dst_we,
    input  logic [IDX_W-1:0]         dst_idx,
    input  logic                     term_exc,
    input  logic                     resum_exc,
    input  logic                     is_store,
    input  logic                     restore_we,
    input  logic                     any_hit,
    output logic                     illegal_nxt,
    output logic                     fault_nxt,
    output logic                     resum_nxt,
    output poison_pkg::wr_act_e      wr_act
);

    logic live;

    assign live = op_valid & ~restore_we;

    // Flag outcomes for the registered outputs
    always_comb begin
        illegal_nxt = live & is_store & op_spec;
        fault_nxt   = live & ~op_spec & any_hit;
        resum_nxt   = live & resum_exc & ~(is_store & op_spec);
    end

    // Destination poison action: set, clear or leave alone
    always_comb begin
        wr_act = poison_pkg::WR_NONE;
        if (live && dst_we && !is_store && dst_idx != '0 && !(~op_spec & any_hit)) begin
            if (op_spec && (any_hit || term_exc))
                wr_act = poison_pkg::WR_SET;
            else
                wr_act = poison_pkg::WR_CLEAR;
        end
    end

endmodule

// File: rtl/poison_store.sv
// Module: the poison bit array. Bit 0 is tied low; the other bits reset
// to clean, load from the restore vector, or take the single write.
// Assumes: restore and write never both matter in one cycle (restore wins).
module poison_store #(
    parameter int NREG  = poison_pkg::DEF_NREG,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 restore_we,
    input  logic [NREG-1:1]      restore_hi,
    input  poison_pkg::wr_act_e  wr_act,
    input  logic [IDX_W-1:0]     wr_idx,
    output logic [NREG-1:0]      state
);

    assign state[0] = 1'b0;

    for (genvar g = 1; g < NREG; g++) begin : g_bit
        // One poison flop per register above 0
        always_ff @(posedge clk) begin
            if (!rst_n)
                state[g] <= 1'b0;
            else if (restore_we)
                state[g] <= restore_hi[g];
            else if (wr_act != poison_pkg::WR_NONE && wr_idx == IDX_W'(g))
                state[g] <= (wr_act == poison_pkg::WR_SET);
        end
    end

endmodule

// File: rtl/poison_tracker.sv
// Module: top of the register poison tracker. Defers terminating
// exceptions of speculative instructions through per-register poison bits
// and raises a fault when a normal instruction consumes a poisoned value.
// Assumes: at most one instruction per cycle; all flags registered once.
module poison_tracker #(
    parameter int NREG  = poison_pkg::DEF_NREG,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic             op_spec,
    input  logic             src0_en,
    input  logic [IDX_W-1:0] src0_idx,
    input  logic             src1_en,
    input  logic [IDX_W-1:0] src1_idx,
    input  logic             dst_we,
    input  logic [IDX_W-1:0] dst_idx,
    input  logic             term_exc,
    input  logic             resum_exc,
    input  logic             is_store,
    input  logic             restore_we,
    input  logic [NREG-1:0]  restore_data,
    output logic             fault,
    output logic [IDX_W-1:0] fault_reg,
    output logic             illegal_store,
    output logic             resum_pass,
    output logic [NREG-1:0]  poison_vec
);

    localparam int NSRC = poison_pkg::DEF_NSRC;

    logic                       any_hit;
    logic [IDX_W-1:0]           cause_idx;
    logic                       illegal_nxt;
    logic                       fault_nxt;
    logic                       resum_nxt;
    poison_pkg::wr_act_e        wr_act;
    logic [NSRC-1:0]            src_en;
    logic [NSRC-1:0][IDX_W-1:0] src_idx;

    assign src_en  = {src1_en, src0_en};
    assign src_idx = {src1_idx, src0_idx};

    poison_src_check #(.NREG(NREG), .NSRC(NSRC), .IDX_W(IDX_W)) u_src (
        .poison_vec (poison_vec),
        .src_en     (src_en),
        .src_idx    (src_idx),
        .any_hit    (any_hit),
        .cause_idx  (cause_idx)
    );

    poison_decide #(.NREG(NREG), .IDX_W(IDX_W)) u_dec (
        .op_valid    (op_valid),
        .op_spec     (op_spec),
        .dst_we      (dst_we),
        .dst_idx     (dst_idx),
        .term_exc    (term_exc),
        .resum_exc   (resum_exc),
        .is_store    (is_store),
        .restore_we  (restore_we),
        .any_hit     (any_hit),
        .illegal_nxt (illegal_nxt),
        .fault_nxt   (fault_nxt),
        .resum_nxt   (resum_nxt),
        .wr_act      (wr_act)
    );

    poison_store #(.NREG(NREG), .IDX_W(IDX_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .restore_we (restore_we),
        .restore_hi (restore_data[NREG-1:1]),
        .wr_act     (wr_act),
        .wr_idx     (dst_idx),
        .state      (poison_vec)
    );

    // Register the per-instruction outcome flags and the fault cause
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault         <= 1'b0;
            fault_reg     <= '0;
            illegal_store <= 1'b0;
            resum_pass    <= 1'b0;
        end else begin
            fault         <= fault_nxt;
            fault_reg     <= fault_nxt ? cause_idx : '0;
            illegal_store <= illegal_nxt;
            resum_pass    <= resum_nxt;
        end
    end

endmodule

// File: rtl/poison_tracker_chk.sv
// Module: property checker for the poison tracker, bound to the top.
// Assumes: inputs are settled at every rising edge.
module poison_tracker_chk #(
    parameter int NREG  = 32,
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic             op_spec,
    input logic             src0_en,
    input logic [IDX_W-1:0] src0_idx,
    input logic             src1_en,
    input logic [IDX_W-1:0] src1_idx,
    input logic             dst_we,
    input logic [IDX_W-1:0] dst_idx,
    input logic             term_exc,
    input logic             resum_exc,
    input logic             is_store,
    input logic             restore_we,
    input logic [NREG-1:0]  restore_data,
    input logic             fault,
    input logic [IDX_W-1:0] fault_reg,
    input logic             illegal_store,
    input logic             resum_pass,
    input logic [NREG-1:0]  poison_vec
);

    logic live;
    logic hit_any;
    assign live    = op_valid & ~restore_we;
    assign hit_any = (src0_en & poison_vec[src0_idx]) | (src1_en & poison_vec[src1_idx]);

    // R2: speculative terminating exception poisons the destination
    a_r2_spec_exc_poisons: assert property (@(posedge clk) disable iff (!rst_n)
        live && op_spec && !is_store && dst_we && dst_idx != '0 && term_exc
        |=> poison_vec[$past(dst_idx)] && !fault);

    // R3: speculative read of a poisoned source propagates
    a_r3_spec_propagates: assert property (@(posedge clk) disable iff (!rst_n)
        live && op_spec && !is_store && dst_we && dst_idx != '0 && hit_any
        |=> poison_vec[$past(dst_idx)]);

    // R4: normal read of a poisoned source faults
    a_r4_normal_faults: assert property (@(posedge clk) disable iff (!rst_n)
        live && !op_spec && hit_any |=> fault);

    // R5: reported cause is poisoned and nonzero
    a_r5_cause_poisoned: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (poison_vec[fault_reg] && fault_reg != '0));

    // R5: faulting instruction leaves its destination bit alone
    a_r5_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        live && !op_spec && hit_any && dst_we
        |=> poison_vec[$past(dst_idx)] == $past(poison_vec[dst_idx]));

    // R6: clean normal write clears the destination
    a_r6_normal_clears: assert property (@(posedge clk) disable iff (!rst_n)
        live && !op_spec && !is_store && !hit_any && dst_we && dst_idx != '0
        |=> !poison_vec[$past(dst_idx)]);

    // R7: a write aimed at register 0 changes nothing
    a_r7_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
        live && dst_we && dst_idx == '0 |=> $stable(poison_vec));

    // R8: speculative store is flagged and has no state effect
    a_r8_illegal_store: assert property (@(posedge clk) disable iff (!rst_n)
        live && op_spec && is_store |=> illegal_store && !fault && $stable(poison_vec));

    // R9: resumable exception passes through
    a_r9_resum_pass: assert property (@(posedge clk) disable iff (!rst_n)
        live && resum_exc && !(op_spec && is_store) |=> resum_pass);

    // R10: restore loads the vector with bit 0 clean and mutes outputs
    a_r10_restore: assert property (@(posedge clk) disable iff (!rst_n)
        restore_we |=> (poison_vec == ($past(restore_data) & ~{{(NREG-1){1'b0}}, 1'b1}))
                       && !fault && !illegal_store && !resum_pass);

    // R4: fault cause is zero whenever no fault is shown
    a_r4_cause_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !fault |-> fault_reg == '0);

endmodule

bind poison_tracker poison_tracker_chk #(.NREG(NREG), .IDX_W(IDX_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .op_valid      (op_valid),
    .op_spec       (op_spec),
    .src0_en       (src0_en),
    .src0_idx      (src0_idx),
    .src1_en       (src1_en),
    .src1_idx      (src1_idx),
    .dst_we        (dst_we),
    .dst_idx       (dst_idx),
    .term_exc      (term_exc),
    .resum_exc     (resum_exc),
    .is_store      (is_store),
    .restore_we    (restore_we),
    .restore_data  (restore_data),
    .fault         (fault),
    .fault_reg     (fault_reg),
    .illegal_store (illegal_store),
    .resum_pass    (resum_pass),
    .poison_vec    (poison_vec)
);

// File: tb/sim_poison_tracker.sv
// Bench: behavioural reference model compared with the tracker every cycle.
module sim_poison_tracker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0, op_spec = 1'b0;
    logic        src0_en = 1'b0, src1_en = 1'b0;
    logic [4:0]  src0_idx = '0, src1_idx = '0, dst_idx = '0;
    logic        dst_we = 1'b0, term_exc = 1'b0, resum_exc = 1'b0, is_store = 1'b0;
    logic        restore_we = 1'b0;
    logic [31:0] restore_data = '0;
    logic        fault, illegal_store, resum_pass;
    logic [4:0]  fault_reg;
    logic [31:0] poison_vec;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit [31:0] m_vec;
    bit        e_fault, e_ill, e_res;
    bit [4:0]  e_reg;
    string     tag;

    always #10 clk = ~clk;

    poison_tracker u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_spec(op_spec),
        .src0_en(src0_en), .src0_idx(src0_idx), .src1_en(src1_en), .src1_idx(src1_idx),
        .dst_we(dst_we), .dst_idx(dst_idx), .term_exc(term_exc), .resum_exc(resum_exc),
        .is_store(is_store), .restore_we(restore_we), .restore_data(restore_data),
        .fault(fault), .fault_reg(fault_reg), .illegal_store(illegal_store),
        .resum_pass(resum_pass), .poison_vec(poison_vec)
    );

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        chk(poison_vec === m_vec, "poison_vec", poison_vec, m_vec);
        chk(fault === e_fault, "fault", {31'b0, fault}, {31'b0, e_fault});
        chk(fault_reg === e_reg, "fault_reg", {27'b0, fault_reg}, {27'b0, e_reg});
        chk(illegal_store === e_ill, "illegal_store", {31'b0, illegal_store}, {31'b0, e_ill});
        chk(resum_pass === e_res, "resum_pass", {31'b0, resum_pass}, {31'b0, e_res});
    endtask

    // Drive one cycle at a falling edge, predict, then compare at the next one
    task automatic step(input bit v, input bit sp, input bit e0, input bit [4:0] i0,
                        input bit e1, input bit [4:0] i1, input bit we, input bit [4:0] d,
                        input bit tx, input bit rx, input bit st, input bit rw,
                        input bit [31:0] rd, input string t);
        bit live, h0, h1, any, ill, flt;
        bit [4:0] cause;
        op_valid = v; op_spec = sp; src0_en = e0; src0_idx = i0; src1_en = e1; src1_idx = i1;
        dst_we = we; dst_idx = d; term_exc = tx; resum_exc = rx; is_store = st;
        restore_we = rw; restore_data = rd;
        live = v && !rw;
        h0 = e0 && m_vec[i0];
        h1 = e1 && m_vec[i1];
        any = h0 || h1;
        if (h0 && h1) cause = (i0 < i1) ? i0 : i1;
        else if (h0) cause = i0;
        else cause = i1;
        ill = live && st && sp;
        flt = live && !sp && any;
        e_ill = ill;
        e_fault = flt;
        e_reg = flt ? cause : 5'd0;
        e_res = live && rx && !ill;
        if (rw) m_vec = rd & 32'hFFFF_FFFE;
        else if (live && !ill && !flt && we && !st && d != 0) m_vec[d] = sp && (any || tx);
        if (t != "") tag = t;
        else if (rw) tag = "R10";
        else if (ill) tag = "R8";
        else if (flt) tag = "R4";
        else if (e_res) tag = "R9";
        else if (sp) tag = "R3";
        else tag = "R6";
        @(negedge clk);
        compare();
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m_vec = '0; e_fault = 0; e_reg = 0; e_ill = 0; e_res = 0;
        // R1: reset state
        tag = "R1";
        repeat (3) @(negedge clk);
        compare();
        rst_n = 1'b1;
        // R2: speculative exception poisons r5
        step(1,1, 0,0, 0,0, 1,5, 1,0,0, 0,0, "R2");
        // R3: speculative chain r5 -> r7
        step(1,1, 1,5, 0,0, 1,7, 0,0,0, 0,0, "R3");
        // R3: disabled source pointing at r5 does not count, r8 stays clean
        step(1,1, 1,3, 0,5, 1,8, 0,0,0, 0,0, "R3");
        // R4: normal read of r7 faults
        step(1,0, 0,0, 1,7, 1,9, 0,0,0, 0,0, "R4");
        // R5: both sources poisoned, lower index 5 reported, r7 write dropped
        step(1,0, 1,7, 1,5, 1,7, 0,0,0, 0,0, "R5");
        // R6: clean normal write clears r5
        step(1,0, 1,3, 0,0, 1,5, 1,1,0, 0,0, "R6");
        // R7: speculative exception aimed at r0 changes nothing
        step(1,1, 0,0, 0,0, 1,0, 1,0,0, 0,0, "R7");
        // R7: reading r0 is never a poisoned read
        step(1,0, 1,0, 1,0, 1,11, 0,0,0, 0,0, "R7");
        // R8: speculative store flagged, vector unchanged
        step(1,1, 1,7, 0,0, 1,7, 0,0,1, 0,0, "R8");
        // R8: normal store reading poisoned r7 faults but never writes r7
        step(1,0, 1,7, 0,0, 1,12, 0,0,1, 0,0, "R8");
        // R9: resumable exception passes and leaves r12 clean
        step(1,1, 0,0, 0,0, 1,12, 0,1,0, 0,0, "R9");
        // R10: restore all ones, concurrent op ignored
        step(1,0, 1,7, 0,0, 1,7, 1,1,0, 1,32'hFFFF_FFFF, "R10");
        step(0,0, 0,0, 0,0, 0,0, 0,0,0, 1,32'h0000_0F0F, "R10");
        // Mixed traffic biased to low registers
        for (int n = 0; n < 4000; n++) begin
            bit [4:0] a, b, c;
            a = ($urandom % 4 == 0) ? 5'($urandom) : 5'($urandom % 8);
            b = ($urandom % 4 == 0) ? 5'($urandom) : 5'($urandom % 8);
            c = ($urandom % 4 == 0) ? 5'($urandom) : 5'($urandom % 8);
            step(($urandom % 8) != 0, ($urandom % 2) == 1,
                 ($urandom % 4) != 0, a, ($urandom % 2) == 1, b,
                 ($urandom % 4) != 0, c,
                 ($urandom % 4) == 0, ($urandom % 8) == 0, ($urandom % 8) == 0,
                 ($urandom % 64) == 0, $urandom, "");
        end
        // R1: reset mid-run clears everything
        rst_n = 1'b0;
        op_valid = 1'b0; restore_we = 1'b0;
        m_vec = '0; e_fault = 0; e_reg = 0; e_ill = 0; e_res = 0; tag = "R1";
        @(negedge clk);
        compare();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule